// File: doc/BRIEF.md
# Charge Pump Charging Timer

This block times how long an external charge pump stays in its charging phase. The pump raises a charging-active level. While that level is high and the display controller is enabled, a 13-bit timer counts one step per clock. Charging can end because the pump lowers the level, or because the timer reaches a host-programmed limit. Whichever happens first, the timer freezes and its count is copied into a read-only capture register. The host reads that register to learn how long the last charge took.

Reaching the limit sets a sticky timeout flag. The host clears the flag by writing 1 to it. When the interrupt enable is set, the flag drives a timeout interrupt. At timeout the block also asks the pump to stop charging. While the display controller is disabled, the pump is always told to stop and no timing takes place.

Top module: `cp_charge_timer`

## Requirements
- R1: On the first clock edge that sees chargeActive high with enable high, after a cycle in which that pair was not both high, the timer is set to 0. Each later edge with both high adds 1 to the timer.
- R2: Suppose the pair was high for N edges (N at least 1) without a timeout. The first edge that sees it not both high then loads N-1 into captureTime and stops the timer. Dropping enable ends charging in the same way.
- R3: When an increment would make the timer greater than or equal to timeoutVal, that edge sets timeoutFlag and loads the new count (equal to timeoutVal when timeoutVal is held steady) into captureTime. From that edge on the timer stays frozen until the next start.
- R4: When timeoutVal is 0, the start edge itself sets timeoutFlag, loads 0 into captureTime and does not start the timer.
- R5: An edge with flagClrWr high and flagClrData high clears timeoutFlag. A write with flagClrData low has no effect. A timeout on the same edge as a clear leaves the flag set.
- R6: timeoutIrq equals timeoutFlag AND irqEn, with no added cycle of delay.
- R7: stopCharge goes high on the timeout edge and stays high until the first edge that sees charging not active. stopCharge is also high whenever enable is low.
- R8: captureTime keeps its value from one capture to the next. A start edge does not change it.
- R9: After reset, captureTime is 0, timeoutFlag is 0 and timeoutIrq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD operating clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Display controller enabled |
| chargeActive | input | 1 | Pump reports that it is charging |
| timeoutVal | input | 13 | Timeout limit in clock cycles |
| irqEn | input | 1 | Timeout interrupt enable |
| flagClrWr | input | 1 | Host write strobe for the flag |
| flagClrData | input | 1 | Write data; 1 clears the flag |
| captureTime | output | 13 | Count captured at the last stop |
| timeoutFlag | output | 1 | Sticky timeout flag |
| timeoutIrq | output | 1 | Timeout interrupt |
| stopCharge | output | 1 | Request to the pump to stop charging |

## Verification
The hardest cases sit one cycle apart. In one, charging ends on the exact edge where the count would reach the limit, and the timeout must win. In the other, charging ends one edge earlier, and the plain capture must win. The stimulus table holds pulses whose lengths sit on either side of the limit, plus a limit of zero. Directed tests drop enable in the middle of a charge, and issue a clear on the same edge as a timeout.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int CNT_W = 13;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capCnt;
    logic capInc;
    logic capZero;
  } ctlStrobes_t;
endpackage

// File: rtl/cpt_datapath.sv
module cpt_datapath
  import cpt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobes_t  stb,
  input  logic [W-1:0] limit,
  output logic         limitHit,
  output logic         limitZero,
  output logic [W-1:0] capture
);
  logic [W-1:0] count;
  logic [W:0]   nextWide;

  assign nextWide  = {1'b0, count} + {{W{1'b0}}, 1'b1};
  assign limitHit  = nextWide >= {1'b0, limit};
  assign limitZero = (limit == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.clrCnt) begin
      count <= '0;
    end else if (stb.incCnt) begin
      count <= nextWide[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capture <= '0;
    end else if (stb.capZero) begin
      capture <= '0;
    end else if (stb.capInc) begin
      capture <= nextWide[W-1:0];
    end else if (stb.capCnt) begin
      capture <= count;
    end
  end
endmodule

// File: rtl/cpt_control.sv
module cpt_control
  import cpt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        chargeActive,
  input  logic        limitHit,
  input  logic        limitZero,
  input  logic        flagClrWr,
  input  logic        flagClrData,
  output ctlStrobes_t stb,
  output logic        flag,
  output logic        stopReq
);
  logic chgQual;
  logic prevChg;
  logic running;
  logic runNext;
  logic startEdge;
  logic timeoutNow;

  assign chgQual   = chargeActive & enable;
  assign startEdge = chgQual & ~prevChg;

  always_comb begin
    stb        = '0;
    runNext    = running;
    timeoutNow = 1'b0;
    if (startEdge) begin
      stb.clrCnt = 1'b1;
      if (limitZero) begin
        stb.capZero = 1'b1;
        timeoutNow  = 1'b1;
        runNext     = 1'b0;
      end else begin
        runNext = 1'b1;
      end
    end else if (running) begin
      if (!chgQual) begin
        stb.capCnt = 1'b1;
        runNext    = 1'b0;
      end else if (limitHit) begin
        stb.incCnt = 1'b1;
        stb.capInc = 1'b1;
        timeoutNow = 1'b1;
        runNext    = 1'b0;
      end else begin
        stb.incCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevChg <= 1'b0;
      running <= 1'b0;
      flag    <= 1'b0;
      stopReq <= 1'b0;
    end else begin
      prevChg <= chgQual;
      running <= runNext;
      if (timeoutNow) begin
        flag <= 1'b1;
      end else if (flagClrWr && flagClrData) begin
        flag <= 1'b0;
      end
      if (timeoutNow) begin
        stopReq <= 1'b1;
      end else if (!chgQual) begin
        stopReq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cp_charge_timer.sv
module cp_charge_timer
  import cpt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         chargeActive,
  input  logic [W-1:0] timeoutVal,
  input  logic         irqEn,
  input  logic         flagClrWr,
  input  logic         flagClrData,
  output logic [W-1:0] captureTime,
  output logic         timeoutFlag,
  output logic         timeoutIrq,
  output logic         stopCharge
);
  ctlStrobes_t stb;
  logic limitHit;
  logic limitZero;
  logic stopReq;

  cpt_control u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .chargeActive(chargeActive),
    .limitHit(limitHit), .limitZero(limitZero),
    .flagClrWr(flagClrWr), .flagClrData(flagClrData),
    .stb(stb), .flag(timeoutFlag), .stopReq(stopReq)
  );

  cpt_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .limit(timeoutVal),
    .limitHit(limitHit), .limitZero(limitZero), .capture(captureTime)
  );

  assign timeoutIrq = timeoutFlag & irqEn;
  assign stopCharge = stopReq | ~enable;
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         rstN,
  input logic         enable,
  input logic         chargeActive,
  input logic [W-1:0] timeoutVal,
  input logic         irqEn,
  input logic         flagClrWr,
  input logic         flagClrData,
  input logic [W-1:0] captureTime,
  input logic         timeoutFlag,
  input logic         timeoutIrq,
  input logic         stopCharge
);
  p_stop_when_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> stopCharge);

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !timeoutIrq);

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagClrWr && flagClrData && !chargeActive) |=> !timeoutFlag);

  p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!chargeActive && $past(!chargeActive)) |=> $stable(captureTime));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (captureTime >= $past(timeoutVal)));
endmodule

bind cp_charge_timer cpt_checker #(.W(W)) u_cpt_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .chargeActive(chargeActive),
  .timeoutVal(timeoutVal), .irqEn(irqEn), .flagClrWr(flagClrWr),
  .flagClrData(flagClrData), .captureTime(captureTime),
  .timeoutFlag(timeoutFlag), .timeoutIrq(timeoutIrq), .stopCharge(stopCharge)
);

// File: tb/cp_charge_timer_bench.sv
module cp_charge_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        chargeActive = 1'b0;
  logic [12:0] timeoutVal = 13'd0;
  logic        irqEn = 1'b0;
  logic        flagClrWr = 1'b0;
  logic        flagClrData = 1'b0;
  logic [12:0] captureTime;
  logic        timeoutFlag;
  logic        timeoutIrq;
  logic        stopCharge;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cp_charge_timer u_cp_charge_timer (
    .clk(clk), .rstN(rstN), .enable(enable), .chargeActive(chargeActive),
    .timeoutVal(timeoutVal), .irqEn(irqEn), .flagClrWr(flagClrWr),
    .flagClrData(flagClrData), .captureTime(captureTime),
    .timeoutFlag(timeoutFlag), .timeoutIrq(timeoutIrq), .stopCharge(stopCharge)
  );

  // limit, pulse edges, irq enable, expected capture, flag, irq, stop before drop
  typedef struct packed {
    logic [12:0] lim;
    logic [7:0]  edges;
    logic        ien;
    logic [12:0] expCap;
    logic        expFlag;
    logic        expIrq;
    logic        expStop;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{13'd10,  8'd5,  1'b1, 13'd4,  1'b0, 1'b0, 1'b0},
    '{13'd3,   8'd8,  1'b1, 13'd3,  1'b1, 1'b1, 1'b1},
    '{13'd0,   8'd4,  1'b1, 13'd0,  1'b1, 1'b1, 1'b1},
    '{13'd6,   8'd7,  1'b0, 13'd6,  1'b1, 1'b0, 1'b1},
    '{13'd6,   8'd6,  1'b1, 13'd5,  1'b0, 1'b0, 1'b0},
    '{13'd100, 8'd1,  1'b1, 13'd0,  1'b0, 1'b0, 1'b0},
    '{13'd20,  8'd20, 1'b1, 13'd19, 1'b0, 1'b0, 1'b0},
    '{13'd1,   8'd2,  1'b1, 13'd1,  1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearFlag(input logic data);
    @(negedge clk);
    flagClrWr = 1'b1;
    flagClrData = data;
    @(negedge clk);
    flagClrWr = 1'b0;
    flagClrData = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state; R7 stop forced while disabled
    check("R9 capture", captureTime, 0);
    check("R9 flag", timeoutFlag, 0);
    check("R9 irq", timeoutIrq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 stop while disabled", stopCharge, 1);
    enable = 1'b1;
    @(negedge clk);
    check("R7 stop released when enabled", stopCharge, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      timeoutVal = VECS[i].lim;
      irqEn = VECS[i].ien;
      chargeActive = 1'b1;
      repeat (VECS[i].edges) @(negedge clk);
      check($sformatf("R7 stop before drop v%0d", i), stopCharge, VECS[i].expStop);
      if (i == 0) check("R8 start keeps capture", captureTime, 0);
      chargeActive = 1'b0;
      @(negedge clk);
      check($sformatf("R2/R3/R4 capture v%0d", i), captureTime, VECS[i].expCap);
      check($sformatf("R3/R4 flag v%0d", i), timeoutFlag, VECS[i].expFlag);
      check($sformatf("R6 irq v%0d", i), timeoutIrq, VECS[i].expIrq);
      check($sformatf("R7 stop after drop v%0d", i), stopCharge, 0);
      if (VECS[i].expFlag) begin
        clearFlag(1'b0);
        check($sformatf("R5 write zero keeps flag v%0d", i), timeoutFlag, 1);
        clearFlag(1'b1);
        check($sformatf("R5 write one clears v%0d", i), timeoutFlag, 0);
      end
      repeat (3) @(negedge clk);
      check($sformatf("R8 capture holds v%0d", i), captureTime, VECS[i].expCap);
    end

    // R6: flag set with irq disabled, then enabling raises irq at once
    irqEn = 1'b0;
    timeoutVal = 13'd2;
    chargeActive = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 irq masked", timeoutIrq, 0);
    irqEn = 1'b1;
    #1;
    check("R6 irq follows enable", timeoutIrq, 1);
    chargeActive = 1'b0;
    clearFlag(1'b1);

    // R5: clear on the same edge as a timeout leaves the flag set
    @(negedge clk);
    timeoutVal = 13'd3;
    chargeActive = 1'b1;
    repeat (3) @(negedge clk);
    flagClrWr = 1'b1;
    flagClrData = 1'b1;
    @(negedge clk);
    flagClrWr = 1'b0;
    flagClrData = 1'b0;
    check("R5 set wins over clear", timeoutFlag, 1);
    check("R3 capture at limit", captureTime, 3);
    chargeActive = 1'b0;
    clearFlag(1'b1);

    // R2: dropping enable mid-charge captures; R1 restart counts from zero
    @(negedge clk);
    timeoutVal = 13'd500;
    chargeActive = 1'b1;
    repeat (9) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 disable captures", captureTime, 8);
    check("R7 stop while disabled mid-charge", stopCharge, 1);
    repeat (5) @(negedge clk);
    check("R8 no timing while disabled", captureTime, 8);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chargeActive = 1'b0;
    @(negedge clk);
    check("R1 restart counts from zero", captureTime, 3);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule